// File: doc/BRIEF.md
# Global-History Hashed Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the branch's fetch address together with the outcomes of the most recent resolved branches. The word-aligned part of the fetch address is XORed with a short global outcome history. The result selects one 2-bit saturating counter in a small pattern table, and the counter's upper bit is the guess. Because the history takes part in the selection, the same branch can train and read different counters depending on what happened just before it.

The fetch side presents an address and, in the same cycle, gets back a direction and the table slot that produced it. The front end keeps that slot alongside the branch. When the branch resolves, the resolve side returns the slot and the real outcome. The counter in that slot moves one step toward the outcome, and the outcome is shifted into the history. The table is a plain register array with a single-cycle combinational read. A lookup and a training write may occur in the same cycle.

Top module: `gxp_predictor`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted at a clock edge, every counter returns to weakly taken (binary 10) and the history clears to all zeros. After reset, every slot therefore predicts taken, and the slot reported for a fetch address equals its aligned index bits.
- R2: The slot `pred_idx_o` equals bits [ALIGN+IDX_W-1:ALIGN] of `fetch_pc_i` (bits [4:2] by default) XORed with the history, with the history zero-extended to IDX_W bits.
- R3: On each edge with `upd_valid_i` high, the history shifts left one place, takes `upd_taken_i` (1 = taken, 0 = not taken) into bit 0, and drops its top bit. Without `upd_valid_i` it holds.
- R4: A taken update raises the addressed counter by one, and a counter at 3 stays at 3.
- R5: A not-taken update lowers the addressed counter by one, and a counter at 0 stays at 0.
- R6: `pred_taken_o` is 1 when the selected counter holds 2 or 3, and 0 when it holds 0 or 1.
- R7: An update changes only the counter named by `upd_idx_i`, which is the slot the prediction returned. The counter is not recomputed from the current history, and all other counters keep their values.
- R8: When a lookup and an update happen in the same cycle, the lookup returns the direction and slot from the state before that update.
- R9: From reset, a branch with aligned index 011 resolving T, N, T, N, T, each trained through its own returned slot in the same cycle, uses slots 011, 010, 001, 110, 001. All five predictions are taken, and the history ends at 101.
- R10: Two fetch addresses that land on the same slot share one counter, so training through one of them changes the prediction seen by the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc_i | input | PC_W | Fetch address of the branch being looked up |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_idx_o | output | IDX_W | Table slot used for this lookup |
| upd_valid_i | input | 1 | A resolved branch is being reported this cycle |
| upd_idx_i | input | IDX_W | Slot returned by that branch's lookup |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
A directed walk through the alternating five-branch sequence separates a correct XOR hash and history shift from one that uses PC bits alone or shifts the wrong way. It does this through the exact slot sequence and the final history. Runs of repeated taken and not-taken updates into one slot, followed by a reverse step, show whether the counter saturates or wraps at both ends. A scan of every other slot then shows that the training stayed in that one slot. Two addresses that collide on a slot, and lookups that share a cycle with updates to the same slot, expose stray writes and reads that see post-update state. A long seeded random mix of addresses, update slots and outcomes is then compared cycle by cycle against a bench-side model of the counters and history.

// File: rtl/gxp_pkg.sv
package gxp_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'b00;
   localparam ctr_t CTR_WEAK_TAKEN = 2'b10;
   localparam ctr_t CTR_STRONG_T  = 2'b11;

   // one saturating training step toward the resolved outcome
   function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
      ctr_t res;
      if (taken) res = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
      else       res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return res;
   endfunction

   function automatic logic ctr_dir(input ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/gxp_hist_reg.sv
module gxp_hist_reg #(
   parameter int HIST_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [HIST_W-1:0] hist_o
);

   logic [HIST_W-1:0] hist_r;

   generate
      if (HIST_W == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)           hist_r <= '0;
            else if (shift_en) hist_r <= bit_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst)           hist_r <= '0;
            else if (shift_en) hist_r <= {hist_r[HIST_W-2:0], bit_in};
         end
      end
   endgenerate

   assign hist_o = hist_r;

endmodule

// File: rtl/gxp_index_hash.sv
module gxp_index_hash #(
   parameter int IDX_W  = 3,
   parameter int HIST_W = 3
) (
   input  logic [IDX_W-1:0]  pc_bits_i,
   input  logic [HIST_W-1:0] hist_i,
   output logic [IDX_W-1:0]  idx_o
);

   logic [IDX_W-1:0] hist_ext;

   generate
      if (HIST_W == IDX_W) begin : g_full
         assign hist_ext = hist_i;
      end else begin : g_narrow
         localparam int PAD_W = IDX_W - HIST_W;
         assign hist_ext = {{PAD_W{1'b0}}, hist_i};
      end
   endgenerate

   assign idx_o = pc_bits_i ^ hist_ext;

endmodule

// File: rtl/gxp_ctr_table.sv
module gxp_ctr_table
   import gxp_pkg::*;
#(
   parameter int   IDX_W    = 3,
   parameter ctr_t INIT_CTR = CTR_WEAK_TAKEN,
   localparam int  DEPTH    = 1 << IDX_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic               rd_taken,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_taken,
   output logic [2*DEPTH-1:0] ctrs_o
);

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         ctr_t ctr_r;
         always_ff @(posedge clk) begin
            if (rst)
               ctr_r <= INIT_CTR;
            else if (wr_en && (wr_idx == IDX_W'(e)))
               ctr_r <= ctr_next(ctr_r, wr_taken);
         end
         assign ctrs_o[2*e +: 2] = ctr_r;
      end
   endgenerate

   assign rd_taken = ctr_dir(ctrs_o[{rd_idx, 1'b0} +: 2]);

endmodule

// File: rtl/gxp_predictor.sv
module gxp_predictor
   import gxp_pkg::*;
#(
   parameter int   PC_W     = 32,
   parameter int   ALIGN    = 2,
   parameter int   IDX_W    = 3,
   parameter int   HIST_W   = 3,
   parameter ctr_t INIT_CTR = CTR_WEAK_TAKEN,
   localparam int  DEPTH    = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PC_W-1:0]  fetch_pc_i,
   output logic             pred_taken_o,
   output logic [IDX_W-1:0] pred_idx_o,
   input  logic             upd_valid_i,
   input  logic [IDX_W-1:0] upd_idx_i,
   input  logic             upd_taken_i
);

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("gxp_predictor: IDX_W must lie in 1..12");
      end
      if (HIST_W < 1 || HIST_W > IDX_W) begin : g_bad_hist
         $error("gxp_predictor: HIST_W must lie in 1..IDX_W");
      end
      if (ALIGN < 0 || PC_W < ALIGN + IDX_W) begin : g_bad_pc
         $error("gxp_predictor: PC_W too narrow for ALIGN + IDX_W");
      end
   endgenerate

   logic [HIST_W-1:0]  hist_q;
   logic [2*DEPTH-1:0] ctr_flat;
   logic [IDX_W-1:0]   pc_bits;
   logic               pc_unused;

   assign pc_bits   = fetch_pc_i[ALIGN +: IDX_W];
   assign pc_unused = ^fetch_pc_i;

   gxp_hist_reg #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (upd_valid_i),
      .bit_in   (upd_taken_i),
      .hist_o   (hist_q)
   );

   gxp_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash (
      .pc_bits_i (pc_bits),
      .hist_i    (hist_q),
      .idx_o     (pred_idx_o)
   );

   gxp_ctr_table #(.IDX_W(IDX_W), .INIT_CTR(INIT_CTR)) u_table (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (pred_idx_o),
      .rd_taken (pred_taken_o),
      .wr_en    (upd_valid_i),
      .wr_idx   (upd_idx_i),
      .wr_taken (upd_taken_i),
      .ctrs_o   (ctr_flat)
   );

endmodule

// File: rtl/gxp_checker.sv
module gxp_checker #(
   parameter int         PC_W     = 32,
   parameter int         ALIGN    = 2,
   parameter int         IDX_W    = 3,
   parameter int         HIST_W   = 3,
   parameter logic [1:0] INIT_CTR = 2'b10,
   localparam int        DEPTH    = 1 << IDX_W
) (
   input logic               clk,
   input logic               rst,
   input logic [PC_W-1:0]    fetch_pc,
   input logic               pred_taken,
   input logic [IDX_W-1:0]   pred_idx,
   input logic               upd_valid,
   input logic [IDX_W-1:0]   upd_idx,
   input logic               upd_taken,
   input logic [HIST_W-1:0]  hist,
   input logic [2*DEPTH-1:0] ctrs
);

   logic               p_valid, p_taken;
   logic [IDX_W-1:0]   p_idx;
   logic [1:0]         p_ctr;
   logic [HIST_W-1:0]  p_hist;
   logic [HIST_W:0]    shifted_unused_top;
   logic [IDX_W-1:0]   hist_ext;
   logic               pc_unused;

   assign shifted_unused_top = {p_hist, p_taken};
   assign hist_ext           = IDX_W'(hist);
   assign pc_unused          = ^fetch_pc;

   always_ff @(posedge clk) begin
      if (rst) begin
         p_valid <= 1'b0;
         p_taken <= 1'b0;
         p_idx   <= '0;
         p_ctr   <= INIT_CTR;
         p_hist  <= '0;
      end else begin
         p_valid <= upd_valid;
         p_taken <= upd_taken;
         p_idx   <= upd_idx;
         p_ctr   <= ctrs[{upd_idx, 1'b0} +: 2];
         p_hist  <= hist;
      end
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      ($past(rst) === 1'b1) |-> (hist == '0 && ctrs == {DEPTH{INIT_CTR}}));

   assert_index_hash_R2: assert property (@(posedge clk) disable iff (rst)
      pred_idx == (fetch_pc[ALIGN +: IDX_W] ^ hist_ext));

   assert_hist_shift_R3: assert property (@(posedge clk) disable iff (rst)
      p_valid |-> hist == shifted_unused_top[HIST_W-1:0]);

   assert_hist_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !p_valid |-> hist == p_hist);

   assert_ctr_up_R4: assert property (@(posedge clk) disable iff (rst)
      (p_valid && p_taken) |->
         ctrs[{p_idx, 1'b0} +: 2] == ((p_ctr == 2'd3) ? 2'd3 : p_ctr + 2'd1));

   assert_ctr_down_R5: assert property (@(posedge clk) disable iff (rst)
      (p_valid && !p_taken) |->
         ctrs[{p_idx, 1'b0} +: 2] == ((p_ctr == 2'd0) ? 2'd0 : p_ctr - 2'd1));

   assert_dir_bit_R6: assert property (@(posedge clk) disable iff (rst)
      pred_taken == ctrs[{pred_idx, 1'b1}]);

endmodule

bind gxp_predictor gxp_checker #(
   .PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .HIST_W(HIST_W), .INIT_CTR(INIT_CTR)
) u_gxp_checker (
   .clk        (clk),
   .rst        (rst),
   .fetch_pc   (fetch_pc_i),
   .pred_taken (pred_taken_o),
   .pred_idx   (pred_idx_o),
   .upd_valid  (upd_valid_i),
   .upd_idx    (upd_idx_i),
   .upd_taken  (upd_taken_i),
   .hist       (hist_q),
   .ctrs       (ctr_flat)
);

// File: tb/gxp_predictor_bench.sv
`timescale 1ns/1ps
module gxp_predictor_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] fetch_pc = '0;
   logic        pred_taken;
   logic [2:0]  pred_idx;
   logic        upd_valid = 1'b0;
   logic [2:0]  upd_idx = '0;
   logic        upd_taken = 1'b0;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [1:0] m_ctr [8];
   logic [2:0] m_hist;
   logic [2:0] last_idx;

   always #2 clk = ~clk;

   gxp_predictor u_gxp_predictor (
      .clk          (clk),
      .rst          (rst),
      .fetch_pc_i   (fetch_pc),
      .pred_taken_o (pred_taken),
      .pred_idx_o   (pred_idx),
      .upd_valid_i  (upd_valid),
      .upd_idx_i    (upd_idx),
      .upd_taken_i  (upd_taken)
   );

   function automatic logic [1:0] model_step(input logic [1:0] c, input logic t);
      if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
      return (c == 2'd0) ? 2'd0 : c - 2'd1;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_ctr[i] = 2'b10;
      m_hist = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; upd_valid = 1'b0;
      repeat (2) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst = 1'b0;
   endtask

   // drive one cycle, check lookup against model (pre-update), then advance model
   task automatic step(input logic [31:0] pc, input logic uv, input logic [2:0] ui,
                       input logic ut, input string tag);
      logic [2:0] e_idx;
      @(negedge clk);
      fetch_pc = pc; upd_valid = uv; upd_idx = ui; upd_taken = ut;
      #1;
      e_idx = pc[4:2] ^ m_hist;
      check({tag, " idx"}, int'(pred_idx), int'(e_idx));
      check({tag, " dir"}, int'(pred_taken), int'(m_ctr[e_idx][1]));
      last_idx = pred_idx;
      @(posedge clk);
      if (uv) begin
         m_ctr[ui] = model_step(m_ctr[ui], ut);
         m_hist = {m_hist[1:0], ut};
      end
   endtask

   task automatic peek(input logic [2:0] slot, input string tag);
      step({27'b0, slot ^ m_hist, 2'b00}, 1'b0, 3'd0, 1'b0, tag);
   endtask

   task automatic train(input logic [2:0] slot, input logic t, input string tag);
      step(32'h0, 1'b1, slot, t, tag);
   endtask

   initial begin
      logic [2:0] exp_seq [5];
      logic       outc    [5];
      exp_seq = '{3'b011, 3'b010, 3'b001, 3'b110, 3'b001};
      outc    = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
      void'($urandom(32'd20240611));
      model_reset();
      do_reset();

      // R1: every slot weakly taken, slot = aligned PC bits
      for (int i = 0; i < 8; i++) begin
         step({27'h1234, 3'(i), 2'b00}, 1'b0, 3'd0, 1'b0, "R1 reset");
         check("R1 reset slot", int'(last_idx), i);
         check("R1 reset taken", int'(pred_taken), 1);
      end

      // R9: worked alternating trace, same-cycle train through returned slot
      do_reset();
      for (int k = 0; k < 5; k++) begin
         step(32'h0000_000C, 1'b1, 3'b011 ^ m_hist, outc[k], "R9 trace");
         check("R9 slot seq", int'(last_idx), int'(exp_seq[k]));
         check("R9 taken", int'(pred_taken), 1);
      end
      step(32'h0, 1'b0, 3'd0, 1'b0, "R3 hist");
      check("R3 final history 101", int'(last_idx), 5);

      // R4 saturation at 3, then one step down stays taken, next not taken
      do_reset();
      for (int k = 0; k < 4; k++) train(3'd5, 1'b1, "R4 up");
      train(3'd5, 1'b0, "R4 down1");
      peek(3'd5, "R4 still taken after 3->2");
      train(3'd5, 1'b0, "R4 down2");
      peek(3'd5, "R4 not taken after 2->1");
      check("R4 dir after sat", int'(pred_taken), 0);
      // R7: other slots untouched
      for (int s = 0; s < 8; s++) if (s != 5) peek(3'(s), "R7 others unchanged");

      // R5 saturation at 0
      for (int k = 0; k < 4; k++) train(3'd2, 1'b0, "R5 down");
      train(3'd2, 1'b1, "R5 up1");
      peek(3'd2, "R5 not taken after 0->1");
      check("R5 dir after floor", int'(pred_taken), 0);
      train(3'd2, 1'b1, "R5 up2");
      peek(3'd2, "R5 taken after 1->2");
      check("R5 dir after two ups", int'(pred_taken), 1);

      // R8: lookup and update of the same slot in one cycle, reads old state
      do_reset();
      train(3'd1, 1'b0, "R8 prep");
      step({27'b0, 3'd1 ^ m_hist, 2'b00}, 1'b1, 3'd1, 1'b1, "R8 same cycle");
      check("R8 sees pre-update not-taken", int'(pred_taken), 0);
      peek(3'd1, "R8 after update");
      check("R8 post-update taken", int'(pred_taken), 1);

      // R10: aliasing addresses share a counter
      do_reset();
      step(32'h0040_0640, 1'b1, 3'd0, 1'b0, "R10 train A");
      step(32'h0040_0640 ^ {27'b0, m_hist, 2'b00}, 1'b1, 3'd0, 1'b0, "R10 train A");
      step(32'h0050_0640 ^ {27'b0, m_hist, 2'b00}, 1'b0, 3'd0, 1'b0, "R10 alias B");
      check("R10 alias slot", int'(last_idx), 0);
      check("R10 alias dir", int'(pred_taken), 0);

      // random mix R2 R3 R4 R5 R6 R7
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] rpc;
         logic        ruv, rut, ruse;
         logic [2:0]  rui;
         rpc  = $urandom;
         ruv  = ($urandom % 4) != 0;
         rut  = 1'($urandom % 2);
         ruse = 1'($urandom % 2);
         rui  = ruse ? last_idx : 3'($urandom % 8);
         step(rpc, ruv, rui, rut, "R2 R3 R6 random");
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule